// File: doc/BRIEF.md
# Vectored Dual-Path Interrupt Controller

This block collects 64 level-sensitive request lines and hands them to a processor over two request wires: a normal one and a fast one. A per-source class bit sends each line down one of the two paths. Software can also raise any line itself through a force bit. Each source has an enable bit, which software can change a whole word at a time or one source at a time by writing the source's number.

On the normal path, every source carries a 4-bit priority. A programmable threshold drops sources whose priority is too low. The controller picks one winner and shows its number and priority in a vector register. On the fast path, the vector register shows the highest-numbered pending source.

Software uses the block through a 32-bit register port. The port has a write strobe and a read strobe and decodes the byte address. Reads return data in the same cycle. The two request outputs are registered.

Top module: `ivc_top`

## Requirements
- R1: After reset, the control word (0x00) reads 0 and the threshold (0x04) reads 0x1F. Every enable, class and force bit is 0, every priority is 0, and both request outputs are low.
- R2: Writing a value N below 64 to 0x08 sets the enable of source N, and writing it to 0x0C clears it. No other enable bit changes. A write whose value is 64 or more changes nothing.
- R3: Per-source bit words are split in two, with source n at bit n mod 32. The low word holds sources 0–31 and the high word holds 32–63. The pairs (high/low) are: enable 0x10/0x14, class 0x18/0x1C, raw input 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C, fast pending 0x60/0x64. Enable, class and force are read/write.
- R4: A source requests when its input or its force bit is 1. It is normal-pending when it requests, is enabled, and has class 0. It is fast-pending when it requests, is enabled, and has class 1.
- R5: Source n's priority sits in bits [4·(n mod 8)+3 : 4·(n mod 8)] of the priority word for group g = n/8. That word is at byte offset 0x20 + 4·(7−g) and is read/write.
- R6: Among the eligible normal-pending sources, the one with the largest priority wins. If two or more share the largest priority, the higher source number wins.
- R7: The threshold is 5 bits wide. When it is below 16, a normal source is eligible only if its priority is strictly greater than the threshold. When it is 16 or more, all normal-pending sources are eligible.
- R8: The normal vector (0x40) returns the winner's number in [31:16] and its priority in [15:0]. With no winner it returns 0xFFFF0000.
- R9: The fast vector (0x44) returns the highest-numbered fast-pending source in [31:16] and 0 in [15:0]. With none pending it returns 0xFFFF0000.
- R10: The normal request output is high when a normal winner exists. The fast request output is high when any source is fast-pending. Both go through one register, so a change on an input shows at the output one clock edge later.
- R11: A read of any offset not listed in R1, R3, R5, R8 or R9 returns 0, and so does any cycle with the read strobe low. A write to 0x40, 0x44 or the raw/pending words has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |
| src_in | input | 64 | Level request inputs, one per source |
| irq_norm_o | output | 1 | Registered normal request |
| irq_fast_o | output | 1 | Registered fast request |

## Verification
The bench uses the default parameters: 64 sources and 4-bit priorities. This size is small enough to sweep every source number through enable-by-number, through a lone normal request, and through a lone fast request. It also sweeps all 32 threshold codes against a fixed priority. Several hundred random settings of enables, classes, forces, priorities and thresholds are compared against a scoring model in the bench. That model scans the sources from the top down, so priority ties come up often and are checked against the higher-number rule.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int PRIO_W = 4;
  localparam int LVL_W  = PRIO_W + 1;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_LEVEL  = 8'h04;
  localparam logic [7:0] OFS_SETNUM = 8'h08;
  localparam logic [7:0] OFS_CLRNUM = 8'h0C;
  localparam logic [7:0] OFS_EN_LO  = 8'h14;
  localparam logic [7:0] OFS_CLS_LO = 8'h1C;
  localparam logic [7:0] OFS_NVEC   = 8'h40;
  localparam logic [7:0] OFS_FVEC   = 8'h44;
  localparam logic [7:0] OFS_RAW_LO = 8'h4C;
  localparam logic [7:0] OFS_FRC_LO = 8'h54;
  localparam logic [7:0] OFS_NPD_LO = 8'h5C;
  localparam logic [7:0] OFS_FPD_LO = 8'h64;
  localparam logic [7:0] OFS_PRIO_B = 8'h20;

  // word w of a split bit register sits 4 bytes below word w-1
  function automatic logic [7:0] half_ofs(input logic [7:0] lo_ofs, input int w);
    return lo_ofs - 8'(4 * w);
  endfunction

  // priority groups are laid out in reverse order
  function automatic logic [7:0] prio_ofs(input int g, input int ngrp);
    return OFS_PRIO_B + 8'(4 * (ngrp - 1 - g));
  endfunction

  // threshold of 16 or more lets every priority through
  function automatic logic above_level(input logic [PRIO_W-1:0] prio,
                                       input logic [LVL_W-1:0] lvl);
    return lvl[LVL_W-1] ? 1'b1 : (prio > lvl[PRIO_W-1:0]);
  endfunction

  function automatic logic [31:0] vec_word(input logic hit, input logic [15:0] num,
                                           input logic [15:0] info);
    return hit ? {num, info} : 32'hFFFF_0000;
  endfunction
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int DW   = 32,
  parameter int PW   = PRIO_W,
  localparam int NW    = NSRC / DW,
  localparam int NGRP  = NSRC * PW / DW,
  localparam int NUM_W = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           addr,
  input  logic [DW-1:0]        wdata,
  output logic [NSRC-1:0]      en_q,
  output logic [NSRC-1:0]      cls_q,
  output logic [NSRC-1:0]      frc_q,
  output logic [NSRC*PW-1:0]   prio_q,
  output logic [LVL_W-1:0]     lvl_q,
  output logic [DW-1:0]        ctrl_q
);
  logic [NUM_W-1:0] num;
  logic             num_ok;
  logic             set_hit, clr_hit;

  assign num     = wdata[NUM_W-1:0];
  assign num_ok  = (wdata >> NUM_W) == '0;
  assign set_hit = wr_en && addr == OFS_SETNUM && num_ok;
  assign clr_hit = wr_en && addr == OFS_CLRNUM && num_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cls_q  <= '0;
      frc_q  <= '0;
      prio_q <= '0;
      lvl_q  <= '1;
      ctrl_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NW; w++) begin
        if (addr == half_ofs(OFS_EN_LO, w))  en_q[w*DW +: DW]  <= wdata;
        if (addr == half_ofs(OFS_CLS_LO, w)) cls_q[w*DW +: DW] <= wdata;
        if (addr == half_ofs(OFS_FRC_LO, w)) frc_q[w*DW +: DW] <= wdata;
      end
      for (int g = 0; g < NGRP; g++) begin
        if (addr == prio_ofs(g, NGRP)) prio_q[g*DW +: DW] <= wdata;
      end
      if (set_hit) en_q[num] <= 1'b1;
      if (clr_hit) en_q[num] <= 1'b0;
      if (addr == OFS_CTRL)  ctrl_q <= wdata;
      if (addr == OFS_LEVEL) lvl_q  <= wdata[LVL_W-1:0];
    end
  end

  AST_SETNUM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> en_q[$past(num)]);  // R2
  AST_CLRNUM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !en_q[$past(num)]);  // R2
  AST_NUMWRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_SETNUM || addr == OFS_CLRNUM)) |=> $countones(en_q ^ $past(en_q)) <= 1);  // R2
endmodule

// File: rtl/ivc_norm_arb.sv
module ivc_norm_arb
  import ivc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = PRIO_W,
  localparam int NUM_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio,
  input  logic [LVL_W-1:0]   lvl,
  output logic               win_v,
  output logic [NUM_W-1:0]   win_idx,
  output logic [PW-1:0]      win_prio
);
  logic [NSRC-1:0] elig;

  always_comb begin
    for (int i = 0; i < NSRC; i++) elig[i] = pend[i] && above_level(prio[i*PW +: PW], lvl);
  end

  // ascending scan with >= so a later (higher-numbered) source takes a tie
  always_comb begin
    win_v    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!win_v || prio[i*PW +: PW] >= win_prio)) begin
        win_v    = 1'b1;
        win_idx  = NUM_W'(i);
        win_prio = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/ivc_fast_enc.sv
module ivc_fast_enc #(
  parameter int NSRC = 64,
  localparam int NUM_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  pend,
  output logic             hit,
  output logic [NUM_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i]) begin
        hit = 1'b1;
        idx = NUM_W'(i);
      end
    end
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int DW   = 32,
  parameter int PW   = PRIO_W,
  localparam int NW    = NSRC / DW,
  localparam int NGRP  = NSRC * PW / DW,
  localparam int NUM_W = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [7:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_norm_o,
  output logic            irq_fast_o
);
  logic [NSRC-1:0]    en_q, cls_q, frc_q;
  logic [NSRC*PW-1:0] prio_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [DW-1:0]      ctrl_q;

  ivc_regs #(.NSRC(NSRC), .DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .en_q(en_q), .cls_q(cls_q), .frc_q(frc_q), .prio_q(prio_q),
    .lvl_q(lvl_q), .ctrl_q(ctrl_q)
  );

  // named pending vectors, visible to the assertions
  logic [NSRC-1:0] req_eff, norm_pend, fast_pend;
  assign req_eff   = src_in | frc_q;
  assign norm_pend = req_eff & en_q & ~cls_q;
  assign fast_pend = req_eff & en_q & cls_q;

  logic             norm_v;
  logic [NUM_W-1:0] norm_idx;
  logic [PW-1:0]    norm_prio;
  ivc_norm_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
    .pend(norm_pend), .prio(prio_q), .lvl(lvl_q),
    .win_v(norm_v), .win_idx(norm_idx), .win_prio(norm_prio)
  );

  logic             fast_v;
  logic [NUM_W-1:0] fast_idx;
  ivc_fast_enc #(.NSRC(NSRC)) u_fenc (
    .pend(fast_pend), .hit(fast_v), .idx(fast_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm_o <= 1'b0;
      irq_fast_o <= 1'b0;
    end else begin
      irq_norm_o <= norm_v;
      irq_fast_o <= fast_v;
    end
  end

  logic [DW-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (addr)
      OFS_CTRL:  rd_word = ctrl_q;
      OFS_LEVEL: rd_word = DW'(lvl_q);
      OFS_NVEC:  rd_word = vec_word(norm_v, 16'(norm_idx), 16'(norm_prio));
      OFS_FVEC:  rd_word = vec_word(fast_v, 16'(fast_idx), 16'h0000);
      default:   rd_word = '0;
    endcase
    for (int w = 0; w < NW; w++) begin
      if (addr == half_ofs(OFS_EN_LO, w))  rd_word = en_q[w*DW +: DW];
      if (addr == half_ofs(OFS_CLS_LO, w)) rd_word = cls_q[w*DW +: DW];
      if (addr == half_ofs(OFS_RAW_LO, w)) rd_word = src_in[w*DW +: DW];
      if (addr == half_ofs(OFS_FRC_LO, w)) rd_word = frc_q[w*DW +: DW];
      if (addr == half_ofs(OFS_NPD_LO, w)) rd_word = norm_pend[w*DW +: DW];
      if (addr == half_ofs(OFS_FPD_LO, w)) rd_word = fast_pend[w*DW +: DW];
    end
    for (int g = 0; g < NGRP; g++) begin
      if (addr == prio_ofs(g, NGRP)) rd_word = prio_q[g*DW +: DW];
    end
  end
  assign rdata = rd_en ? rd_word : '0;

  AST_PATHS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_pend & fast_pend) == '0);  // R4
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    norm_v |-> norm_pend[norm_idx]);  // R6
  AST_WIN_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_v && !lvl_q[LVL_W-1]) |-> norm_prio > lvl_q[PW-1:0]);  // R7
  AST_IDLE_NO_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_pend == '0) |-> !norm_v);  // R8
  AST_FAST_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    fast_v |-> (fast_pend >> fast_idx) == NSRC'(1));  // R9
  AST_NORM_REQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    norm_v |=> irq_norm_o);  // R10
  AST_FAST_REQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_v |=> !irq_fast_o);  // R10
endmodule

// File: tb/sim_ivc_top.sv
`timescale 1ns/1ps
module sim_ivc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src_in = '0;
  logic        irq_norm_o, irq_fast_o;

  ivc_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_in(src_in),
    .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  // bench model of the programmed state
  logic [63:0] m_en = '0, m_ty = '0, m_fr = '0;
  logic [3:0]  m_pr [64];
  logic [4:0]  m_lvl = 5'h1F;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] grp_addr(input int g);
    return 8'(8'h3C - 4 * g);
  endfunction

  task automatic put_prio(input int g, input logic [31:0] d);
    wr(grp_addr(g), d);
    for (int k = 0; k < 8; k++) m_pr[g*8+k] = d[4*k +: 4];
  endtask

  function automatic logic [63:0] m_npend();
    return (src_in | m_fr) & m_en & ~m_ty;
  endfunction
  function automatic logic [63:0] m_fpend();
    return (src_in | m_fr) & m_en & m_ty;
  endfunction

  // top-down scan, strict improvement: ties keep the higher number
  function automatic logic [31:0] exp_nvec();
    int best = -1, bp = -1;
    logic [63:0] p = m_npend();
    for (int n = 63; n >= 0; n--)
      if (p[n] && (m_lvl >= 5'd16 || int'(m_pr[n]) > int'(m_lvl)) && int'(m_pr[n]) > bp) begin
        best = n; bp = int'(m_pr[n]);
      end
    return (best < 0) ? 32'hFFFF_0000 : {16'(best), 16'(bp)};
  endfunction

  function automatic logic [31:0] exp_fvec();
    logic [63:0] p = m_fpend();
    for (int n = 63; n >= 0; n--) if (p[n]) return {16'(n), 16'h0};
    return 32'hFFFF_0000;
  endfunction

  task automatic chk_all(input string tag);
    logic [31:0] d;
    rd(8'h40, d); chk({tag, " R6 R8 nvec"}, d, exp_nvec());
    rd(8'h44, d); chk({tag, " R9 fvec"}, d, exp_fvec());
    rd(8'h5C, d); chk({tag, " R4 npend lo"}, d, m_npend()[31:0]);
    rd(8'h58, d); chk({tag, " R4 npend hi"}, d, m_npend()[63:32]);
    rd(8'h64, d); chk({tag, " R4 fpend lo"}, d, m_fpend()[31:0]);
    rd(8'h60, d); chk({tag, " R4 fpend hi"}, d, m_fpend()[63:32]);
    chk({tag, " R10 irq_norm"}, 32'(irq_norm_o), 32'(exp_nvec() != 32'hFFFF_0000));
    chk({tag, " R10 irq_fast"}, 32'(irq_fast_o), 32'(m_fpend() != '0));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int n = 0; n < 64; n++) m_pr[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h04, d); chk("R1 level", d, 32'h1F);
    foreach (d[i]) ;
    for (int a = 8'h10; a <= 8'h1C; a += 4) begin rd(8'(a), d); chk("R1 en/class", d, 0); end
    rd(8'h50, d); chk("R1 force hi", d, 0);
    rd(8'h54, d); chk("R1 force lo", d, 0);
    for (int g = 0; g < 8; g++) begin rd(grp_addr(g), d); chk("R1 prio", d, 0); end
    chk("R1 irq_norm", 32'(irq_norm_o), 0);
    chk("R1 irq_fast", 32'(irq_fast_o), 0);
    rd(8'h40, d); chk("R1 R8 nvec idle", d, 32'hFFFF_0000);

    // R11 control read/write, undefined offsets, read strobe low
    wr(8'h00, 32'hA5C3_0F96); rd(8'h00, d); chk("R11 ctrl rw", d, 32'hA5C3_0F96);
    rd(8'h68, d); chk("R11 undef 0x68", d, 0);
    rd(8'h80, d); chk("R11 undef 0x80", d, 0);
    rd(8'hFC, d); chk("R11 undef 0xFC", d, 0);
    rd(8'h01, d); chk("R11 undef 0x01", d, 0);
    @(negedge clk); addr = 8'h00; #1 chk("R11 no strobe", rdata, 0);

    // R2 enable by number sweep
    for (int n = 0; n < 64; n++) begin
      wr(8'h08, n); m_en[n] = 1'b1;
      rd(8'h14, d); chk("R2 R3 setnum lo", d, m_en[31:0]);
      rd(8'h10, d); chk("R2 R3 setnum hi", d, m_en[63:32]);
    end
    for (int n = 1; n < 64; n += 2) begin
      wr(8'h0C, n); m_en[n] = 1'b0;
      rd(8'h14, d); chk("R2 clrnum lo", d, m_en[31:0]);
      rd(8'h10, d); chk("R2 clrnum hi", d, m_en[63:32]);
    end
    wr(8'h0C, 32'h40); wr(8'h0C, 32'h100); wr(8'h08, 32'h41);
    rd(8'h14, d); chk("R2 big num ignored lo", d, m_en[31:0]);
    rd(8'h10, d); chk("R2 big num ignored hi", d, m_en[63:32]);

    // R3 word writes
    m_en = 64'h0123_4567_89AB_CDEF;
    wr(8'h14, m_en[31:0]); wr(8'h10, m_en[63:32]);
    rd(8'h14, d); chk("R3 en lo", d, m_en[31:0]);
    rd(8'h10, d); chk("R3 en hi", d, m_en[63:32]);
    wr(8'h1C, 32'h5A5A_0001); rd(8'h1C, d); chk("R3 class lo", d, 32'h5A5A_0001);
    wr(8'h18, 32'h8000_00FF); rd(8'h18, d); chk("R3 class hi", d, 32'h8000_00FF);
    wr(8'h1C, 0); wr(8'h18, 0);

    // R5 R6 lone normal source sweep, priority n mod 16, all enabled
    m_en = '1; wr(8'h14, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
    for (int g = 0; g < 8; g++) begin
      logic [31:0] pw;
      for (int k = 0; k < 8; k++) pw[4*k +: 4] = 4'((g*8 + k) % 16);
      put_prio(g, pw);
      rd(grp_addr(g), d); chk("R5 prio rw", d, pw);
    end
    for (int n = 0; n < 64; n++) begin
      src_in = 64'd1 << n;
      @(negedge clk);
      rd(8'h40, d); chk("R5 R8 lone normal", d, (n % 16 == 0 && 1'b0) ? 0 : {16'(n), 16'(n % 16)});
      chk("R10 lone normal irq", 32'(irq_norm_o), 1);
      rd(8'h4C, d); chk("R3 raw lo", d, src_in[31:0]);
      rd(8'h48, d); chk("R3 raw hi", d, src_in[63:32]);
    end

    // R9 lone fast source sweep
    m_ty = '1; wr(8'h1C, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    for (int n = 0; n < 64; n++) begin
      src_in = 64'd1 << n;
      @(negedge clk);
      rd(8'h44, d); chk("R9 lone fast", d, {16'(n), 16'h0});
      chk("R10 lone fast irq", 32'(irq_fast_o), 1);
      chk("R4 fast not normal", 32'(irq_norm_o), 0);
    end
    m_ty = '0; wr(8'h1C, 0); wr(8'h18, 0);

    // R7 threshold sweep: source 13 alone at priority 8
    put_prio(1, 32'h0080_0000);
    src_in = 64'd1 << 13;
    for (int lv = 0; lv < 32; lv++) begin
      wr(8'h04, lv); m_lvl = 5'(lv);
      rd(8'h40, d);
      chk("R7 threshold", d, (lv < 8 || lv >= 16) ? {16'd13, 16'd8} : 32'hFFFF_0000);
      rd(8'h04, d); chk("R7 level rw", d, 32'(lv));
    end
    wr(8'h04, 5'h1F); m_lvl = 5'h1F;

    // R6 directed tie: 3 and 40 both priority 9, 40 wins
    for (int g = 0; g < 8; g++) put_prio(g, 0);
    put_prio(0, 32'h0000_9000); put_prio(5, 32'h0000_0009);
    src_in = (64'd1 << 3) | (64'd1 << 40) | (64'd1 << 20);
    @(negedge clk);
    rd(8'h40, d); chk("R6 tie higher wins", d, {16'd40, 16'd9});

    // R4 force drives a request with input low
    src_in = '0; m_fr = 64'd1 << 33; wr(8'h50, 32'h2); wr(8'h54, 0);
    rd(8'h50, d); chk("R3 force hi", d, 32'h2);
    chk_all("force");

    // R11 read-only writes ignored
    wr(8'h40, 32'h1234_5678); wr(8'h44, 32'h1); wr(8'h48, '1); wr(8'h4C, '1);
    wr(8'h58, '1); wr(8'h5C, '1); wr(8'h60, '1); wr(8'h64, '1);
    rd(8'h48, d); chk("R11 raw ro", d, 0);
    chk_all("R11 ro");
    m_fr = '0; wr(8'h50, 0);

    // R10 one-edge delay
    @(negedge clk);
    src_in = 64'd1 << 5; m_pr[5] = 4'd0;
    #1 chk("R10 before edge", 32'(irq_norm_o), 0);
    @(negedge clk);
    chk("R10 after edge", 32'(irq_norm_o), 1);
    src_in = '0;
    #1 chk("R10 fall before edge", 32'(irq_norm_o), 1);
    @(negedge clk);
    chk("R10 fall after edge", 32'(irq_norm_o), 0);

    // random mixes
    for (int it = 0; it < 300; it++) begin
      m_en = {$urandom, $urandom} | {$urandom, $urandom};
      m_ty = {$urandom, $urandom} & {$urandom, $urandom};
      m_fr = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if (it % 10 == 0) m_fr = '0;
      m_lvl = 5'($urandom % 32);
      wr(8'h14, m_en[31:0]); wr(8'h10, m_en[63:32]);
      wr(8'h1C, m_ty[31:0]); wr(8'h18, m_ty[63:32]);
      wr(8'h54, m_fr[31:0]); wr(8'h50, m_fr[63:32]);
      wr(8'h04, 32'(m_lvl));
      for (int g = 0; g < 8; g++) put_prio(g, (it % 3 == 0) ? ($urandom & 32'h3333_3333) : $urandom);
      src_in = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if (it % 10 == 0) src_in = '0;
      @(negedge clk);
      chk_all("random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule